// File: doc/BRIEF.md
# Transparent Translation Region Matcher

This block decides whether a logical address falls in a transparently mapped region, one that bypasses page-table translation. It holds four 32-bit region descriptors: two consulted for instruction fetches and two for data accesses. Each lookup presents an address, a supervisor flag, a code/data selector and a probe flag. One cycle later the block reports whether a region matched. On a hit, the address is used untranslated and the page walker is not started. The block also reports the permissions, cache policy and user attribute bits of the matching region.

Each descriptor holds:

- an 8-bit base compared against the top byte of the address;
- an 8-bit don't-care mask;
- an enable bit;
- a 2-bit privilege filter;
- a write-protect bit;
- a 2-bit cache policy;
- two user attribute bits.

Descriptors are loaded through a simple write port. Within the pair chosen by the access kind, the lower-numbered descriptor takes priority.

Top module: `tt_region_match`

## Requirements
- R1: A descriptor whose enable bit (bit 15) is 0 never matches; after reset all four descriptors are zero, so every lookup misses and all result outputs are 0.
- R2: The privilege filter in bits 14:13 works as follows. Value 00 matches only lookups with `lk_super`=0. Value 01 matches only lookups with `lk_super`=1. Values 10 and 11 match regardless of privilege.
- R3: Mask bits 23:16 mark address bits 31:24 as don't-care where set. A descriptor matches only if the address top byte equals base bits 31:24 on every bit whose mask bit is 0.
- R4: A hit sets `rs_read` and `rs_exec` to 1. It sets `rs_write` to the inverse of the write-protect bit (bit 2). A miss drives all three to 0.
- R5: Lookups with `lk_code`=1 consult descriptors 0 and 1 only. Lookups with `lk_code`=0 consult descriptors 2 and 3 only. Descriptors are addressed by `cfg_sel`.
- R6: When both descriptors of the consulted pair match, all attributes come from the lower-numbered one.
- R7: On a hit, `rs_cache` carries descriptor bits 6:5 and `rs_uattr` carries bits 9:8. The cache codes are 00 write-through, 01 copyback, 10 uncached serialized and 11 uncached. On a miss, both outputs are 0.
- R8: A probe lookup (`lk_probe`=1) that hits reports `rs_probe_st`=2'b11, meaning transparent and resident. Any other lookup reports 2'b00.
- R9: Results appear with `rs_valid`=1 on the clock edge after the lookup is presented; `rs_valid` is 0 after a cycle with no lookup. A descriptor write takes effect for lookups presented from the next cycle on, and a lookup in the same cycle as the write sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | 2 | Descriptor index (0,1 code; 2,3 data) |
| cfg_data | input | 32 | Descriptor value to write |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Logical address |
| lk_super | input | 1 | Access is supervisor |
| lk_code | input | 1 | Access is an instruction fetch |
| lk_probe | input | 1 | Lookup is a probe |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | A transparent region matched |
| rs_read | output | 1 | Read permitted |
| rs_exec | output | 1 | Execute permitted |
| rs_write | output | 1 | Write permitted |
| rs_cache | output | 2 | Cache policy of the matching region |
| rs_uattr | output | 2 | User attribute bits of the matching region |
| rs_probe_st | output | 2 | Probe status {transparent, resident} |

## Verification
Directed lookups take one descriptor through all four privilege filter codes with both privilege levels, which separates the user-only, supervisor-only and ignore cases. Further directed cases cover:

- addresses inside and just outside a masked range, which show whether the mask excludes the intended bits;
- identical descriptors placed in the code and data pairs, which show that the access kind selects the pair;
- two overlapping descriptors with different attributes, which show the priority;
- a write and a lookup in the same cycle, which shows which descriptor value the lookup uses.

Random descriptors with top bytes drawn from a small set, followed by lookups, then exercise enable, mask, privilege and protection combinations against a bench model.

// File: rtl/ttm_pkg.sv
package ttm_pkg;
   localparam int DESC_W  = 32;
   localparam int BASE_HI = 31;
   localparam int BASE_LO = 24;
   localparam int MASK_HI = 23;
   localparam int MASK_LO = 16;
   localparam int EN_BIT  = 15;
   localparam int PRIV_HI = 14;
   localparam int PRIV_LO = 13;
   localparam int UA_HI   = 9;
   localparam int UA_LO   = 8;
   localparam int CM_HI   = 6;
   localparam int CM_LO   = 5;
   localparam int WP_BIT  = 2;

   typedef enum logic [1:0] {
      PRIV_USER_ONLY  = 2'b00,
      PRIV_SUPER_ONLY = 2'b01,
      PRIV_EITHER_A   = 2'b10,
      PRIV_EITHER_B   = 2'b11
   } priv_filter_e;

   typedef enum logic [1:0] {
      CACHE_WTHRU   = 2'b00,
      CACHE_COPYBK  = 2'b01,
      CACHE_SERIAL  = 2'b10,
      CACHE_NONE    = 2'b11
   } cache_pol_e;

   typedef struct packed {
      logic       hit;
      logic       rd;
      logic       ex;
      logic       wr;
      cache_pol_e cache;
      logic [1:0] uattr;
      logic [1:0] pstat;
   } ttm_result_t;
endpackage

// File: rtl/ttm_regbank.sv
module ttm_regbank #(
   parameter int NREG = 4,
   parameter int DW   = 32,
   localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [SEL_W-1:0]          sel,
   input  logic [DW-1:0]             wdata,
   output logic [NREG-1:0][DW-1:0]   q
);
   generate
      for (genvar g = 0; g < NREG; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[g] <= '0;
            else if (we && (sel == SEL_W'(g)))
               q[g] <= wdata;
         end
      end
   endgenerate

   // A write lands in the addressed slot on the next edge (R9)
   assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (int'(sel) < NREG)) |=> (q[$past(sel)] == $past(wdata)));
endmodule

// File: rtl/ttm_entry_cmp.sv
module ttm_entry_cmp
   import ttm_pkg::*;
#(
   parameter int TAG_W = 8
) (
   input  logic [DESC_W-1:0] cfg,
   input  logic [TAG_W-1:0]  tag,
   input  logic              sup,
   output logic              match
);
   localparam int FIELD_W = BASE_HI - BASE_LO + 1;

   generate
      if (TAG_W != FIELD_W) begin : g_bad_tag
         $error("ttm_entry_cmp: TAG_W must equal the base field width");
      end
   endgenerate

   logic [TAG_W-1:0] base_f, mask_f, diff;
   priv_filter_e     priv_f;
   logic             priv_ok;

   always_comb begin
      base_f = cfg[BASE_HI:BASE_LO];
      mask_f = cfg[MASK_HI:MASK_LO];
      priv_f = priv_filter_e'(cfg[PRIV_HI:PRIV_LO]);
      diff   = (tag ^ base_f) & ~mask_f;
      unique case (priv_f)
         PRIV_USER_ONLY:  priv_ok = !sup;
         PRIV_SUPER_ONLY: priv_ok = sup;
         default:         priv_ok = 1'b1;
      endcase
      match = cfg[EN_BIT] && priv_ok && (diff == '0);
   end
endmodule

// File: rtl/ttm_pick.sv
module ttm_pick #(
   parameter int N = 2,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end

   // The chosen slot requests and no lower slot does (R6)
   always_comb begin
      if (any) begin
         assert_pick_lowest_R6: assert (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0));
      end
   end
endmodule

// File: rtl/tt_region_match.sv
module tt_region_match
   import ttm_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int PER_SIDE = 2,
   localparam int NREG  = 2 * PER_SIDE,
   localparam int SEL_W = $clog2(NREG),
   localparam int PW    = (PER_SIDE > 1) ? $clog2(PER_SIDE) : 1,
   localparam int TAG_W = BASE_HI - BASE_LO + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [31:0]       cfg_data,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic              lk_super,
   input  logic              lk_code,
   input  logic              lk_probe,
   output logic              rs_valid,
   output logic              rs_hit,
   output logic              rs_read,
   output logic              rs_exec,
   output logic              rs_write,
   output logic [1:0]        rs_cache,
   output logic [1:0]        rs_uattr,
   output logic [1:0]        rs_probe_st
);
   generate
      if (PER_SIDE < 1) begin : g_bad_side
         $error("tt_region_match: PER_SIDE must be at least 1");
      end
      if (ADDR_W < TAG_W) begin : g_bad_addr
         $error("tt_region_match: ADDR_W narrower than the base field");
      end
   endgenerate

   logic [NREG-1:0][DESC_W-1:0] desc;
   logic [NREG-1:0]             hits;
   logic [PER_SIDE-1:0]         side_hits;
   logic                        any_hit;
   logic [PW-1:0]               loc_idx;
   logic [SEL_W-1:0]            win_idx;
   logic [DESC_W-1:0]           win_desc;
   ttm_result_t                 res_d, res_q;

   ttm_regbank #(.NREG(NREG), .DW(DESC_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
      .wdata(cfg_data), .q(desc)
   );

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_cmp
         ttm_entry_cmp #(.TAG_W(TAG_W)) u_cmp (
            .cfg(desc[g]), .tag(lk_addr[ADDR_W-1 -: TAG_W]),
            .sup(lk_super), .match(hits[g])
         );
      end
   endgenerate

   assign side_hits = lk_code ? hits[PER_SIDE-1:0] : hits[NREG-1:PER_SIDE];

   ttm_pick #(.N(PER_SIDE)) u_pick (
      .req(side_hits), .any(any_hit), .idx(loc_idx)
   );

   always_comb begin
      win_idx  = lk_code ? SEL_W'(loc_idx) : SEL_W'(loc_idx) + SEL_W'(PER_SIDE);
      win_desc = desc[win_idx];
      res_d    = '0;
      if (lk_valid && any_hit) begin
         res_d.hit   = 1'b1;
         res_d.rd    = 1'b1;
         res_d.ex    = 1'b1;
         res_d.wr    = !win_desc[WP_BIT];
         res_d.cache = cache_pol_e'(win_desc[CM_HI:CM_LO]);
         res_d.uattr = win_desc[UA_HI:UA_LO];
         res_d.pstat = lk_probe ? 2'b11 : 2'b00;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q    <= '0;
         rs_valid <= 1'b0;
      end else begin
         res_q    <= res_d;
         rs_valid <= lk_valid;
      end
   end

   assign rs_hit      = res_q.hit;
   assign rs_read     = res_q.rd;
   assign rs_exec     = res_q.ex;
   assign rs_write    = res_q.wr;
   assign rs_cache    = res_q.cache;
   assign rs_uattr    = res_q.uattr;
   assign rs_probe_st = res_q.pstat;

   assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rs_valid);
   assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> (!rs_valid && !rs_hit));
   assert_hit_perms_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rs_hit |-> (rs_read && rs_exec));
   assert_write_needs_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_write || rs_read || rs_exec) |-> rs_hit);
   assert_miss_attrs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_hit |-> ((rs_cache == 2'b00) && (rs_uattr == 2'b00)));
   assert_probe_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rs_probe_st != 2'b00) |-> (rs_hit && (rs_probe_st == 2'b11)));
   assert_side_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && (side_hits != '0)) |=> rs_hit);
endmodule

// File: tb/sim_tt_region_match.sv
module sim_tt_region_match;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_data = '0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        lk_super = 1'b0;
   logic        lk_code = 1'b0;
   logic        lk_probe = 1'b0;
   logic        rs_valid, rs_hit, rs_read, rs_exec, rs_write;
   logic [1:0]  rs_cache, rs_uattr, rs_probe_st;

   int checks = 0;
   int errors = 0;
   logic [31:0] model [4];

   always #2 clk = ~clk;

   tt_region_match u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_data(cfg_data), .lk_valid(lk_valid), .lk_addr(lk_addr),
      .lk_super(lk_super), .lk_code(lk_code), .lk_probe(lk_probe),
      .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_read(rs_read),
      .rs_exec(rs_exec), .rs_write(rs_write), .rs_cache(rs_cache),
      .rs_uattr(rs_uattr), .rs_probe_st(rs_probe_st)
   );

   function automatic logic [10:0] f_expect(input logic [31:0] a, input bit s,
                                            input bit c, input bit p);
      for (int k = 0; k < 2; k++) begin
         logic [31:0] d;
         bit pok;
         d = model[c ? k : k + 2];
         pok = (d[14:13] == 2'b00) ? !s : (d[14:13] == 2'b01) ? s : 1'b1;
         if (d[15] && pok && (((a[31:24] ^ d[31:24]) & ~d[23:16]) == 8'h00))
            return {1'b1, 1'b1, 1'b1, !d[2], d[6:5], d[9:8], p ? 2'b11 : 2'b00};
      end
      return 11'd0;
   endfunction

   function automatic logic [10:0] f_actual();
      return {rs_hit, rs_read, rs_exec, rs_write, rs_cache, rs_uattr, rs_probe_st};
   endfunction

   task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
      model[sel] = d;
   endtask

   task automatic look(input string tag, input logic [31:0] a, input bit s,
                       input bit c, input bit p);
      logic [10:0] e;
      e = f_expect(a, s, c, p);
      lk_valid = 1'b1; lk_addr = a; lk_super = s; lk_code = c; lk_probe = p;
      @(negedge clk);
      lk_valid = 1'b0;
      chk({tag, " R9 valid"}, {10'd0, rs_valid}, 11'd1);
      chk(tag, f_actual(), e);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog R9 actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 4; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset outputs", {f_actual()[10:1], rs_valid}, 11'd0);
      look("R1 reset descriptors miss", 32'h4012_3456, 1'b1, 1'b1, 1'b0);

      wr(2'd0, 32'h4000_0220);
      look("R1 disabled never hits", 32'h4012_3456, 1'b0, 1'b1, 1'b0);

      wr(2'd0, 32'h4000_8220);
      look("R2 user-only user", 32'h4012_3456, 1'b0, 1'b1, 1'b0);
      chk("R7 cache/uattr", {7'd0, rs_cache, rs_uattr}, 11'b01_10);
      look("R2 user-only super", 32'h4012_3456, 1'b1, 1'b1, 1'b0);
      chk("R2 user-only super miss", {10'd0, rs_hit}, 11'd0);
      wr(2'd0, 32'h4000_A220);
      look("R2 super-only user", 32'h4012_3456, 1'b0, 1'b1, 1'b0);
      look("R2 super-only super", 32'h4012_3456, 1'b1, 1'b1, 1'b0);
      wr(2'd0, 32'h4000_C220);
      look("R2 either(10) user", 32'h4000_0000, 1'b0, 1'b1, 1'b0);
      look("R2 either(10) super", 32'h40FF_FFFF, 1'b1, 1'b1, 1'b0);
      wr(2'd0, 32'h4000_E220);
      look("R2 either(11) user", 32'h4000_0010, 1'b0, 1'b1, 1'b0);
      look("R3 exact base mismatch", 32'h4100_0010, 1'b0, 1'b1, 1'b0);

      wr(2'd1, 32'h800F_C064);
      look("R3 masked inside", 32'h8A00_1000, 1'b0, 1'b1, 1'b0);
      chk("R4 write-protected", {8'd0, rs_read, rs_exec, rs_write}, 11'b110);
      look("R3 masked outside", 32'h9000_1000, 1'b0, 1'b1, 1'b0);
      look("R5 data pair empty", 32'h8A00_1000, 1'b0, 1'b0, 1'b0);
      chk("R5 data miss", {10'd0, rs_hit}, 11'd0);
      wr(2'd2, 32'h800F_C064);
      look("R5 data pair hit", 32'h8A00_1000, 1'b1, 1'b0, 1'b0);
      wr(2'd0, 32'h80FF_C100);
      look("R6 lower index wins", 32'h8A00_1000, 1'b0, 1'b1, 1'b0);
      chk("R6 attrs from slot 0", {7'd0, rs_cache, rs_uattr}, 11'b00_01);
      look("R8 probe hit", 32'h8A00_1000, 1'b0, 1'b1, 1'b1);
      chk("R8 probe status", {9'd0, rs_probe_st}, 11'b11);
      look("R8 probe miss", 32'h2000_0000, 1'b0, 1'b0, 1'b1);

      // same-cycle write and lookup: lookup sees the old descriptor
      cfg_we = 1'b1; cfg_sel = 2'd3; cfg_data = 32'h2000_C0E0;
      lk_valid = 1'b1; lk_addr = 32'h2000_0004; lk_super = 1'b0; lk_code = 1'b0; lk_probe = 1'b0;
      begin
         logic [10:0] e_old;
         e_old = f_expect(32'h2000_0004, 1'b0, 1'b0, 1'b0);
         @(negedge clk);
         cfg_we = 1'b0; lk_valid = 1'b0;
         chk("R9 same-cycle old value", f_actual(), e_old);
      end
      model[3] = 32'h2000_C0E0;
      look("R9 write visible next", 32'h2000_0004, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      chk("R9 idle cycle", {f_actual()[10], 9'd0, rs_valid}, 11'd0);

      for (int n = 0; n < 600; n++) begin
         if (($urandom % 4) == 0) begin
            logic [7:0] tops [4];
            logic [31:0] d;
            tops[0] = 8'h00; tops[1] = 8'h40; tops[2] = 8'hC0; tops[3] = 8'h41;
            d = $urandom;
            d[31:24] = tops[$urandom % 4];
            d[23:16] = (($urandom % 2) == 0) ? 8'h00 : 8'(1 << ($urandom % 8));
            d[15] = (($urandom % 4) != 0);
            wr(2'($urandom % 4), d);
         end else begin
            logic [31:0] a;
            a = $urandom;
            a[31:24] = (($urandom % 2) == 0) ? 8'(8'h40 | 8'($urandom % 2)) : 8'($urandom);
            look("R3 R4 R6 random lookup", a, 1'($urandom), 1'($urandom), 1'($urandom));
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule